// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Patcher

This block runs after a Reed-Solomon decoder has finished with a sector. It takes the decoder's status word and a small set of error-report words, and applies each correction to a byte-addressable sector buffer through a simple synchronous memory port. Code symbols are 9 bits wide and sit back to back in the byte stream. A single correction can therefore cover two adjacent bytes, and each one is carried out as a read-modify-write of a little-endian 16-bit window.

A controller pulses `start_i` with the status word and report words on its inputs. The block captures them, works through the reports in order, and ends with a one-cycle `done_o` pulse. After that pulse, `fixed_cnt_o` gives the number of symbols patched, and `fail_o` is set if the decoder declared the sector uncorrectable. The syndrome, locator and magnitude computation is not part of this block. Its outputs arrive as input words.

Top module: `rs_sym_patcher`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fail_o`, `mem_rd_o` and `mem_we_o` are low and `fixed_cnt_o` is zero.
- R2: A `start_i` pulse seen while idle captures `status_i` and `reports_i`. `busy_o` is high from the next cycle until `done_o` has been given. A `start_i` seen while busy is ignored.
- R3: If the uncorrectable flag (status bit 1) is set, no byte is written, `fail_o` goes high and `fixed_cnt_o` is zero.
- R4: If the error-present flag (status bit 0) is clear and bit 1 is clear, no byte is written, `fail_o` is low and `fixed_cnt_o` is zero.
- R5: The report count comes from status bits 31:29. The block uses the smaller of this count and MAX_REPS, and processes reports 0 to count-1 in that order. Report k is bits 32k+31:32k of `reports_i`.
- R6: In a report word, bits 24:16 hold a 1-based symbol index and bits 8:0 hold a 9-bit XOR mask. The effective index is field-1. A report whose field is 0, or whose effective index is SYM_LIMIT or more, is skipped and not counted.
- R7: For effective index i, the first byte is A = i + (i >> 3) and the bit offset is i & 7. The mask shifted left by the offset is XORed into the 16-bit window {byte A+1, byte A}.
- R8: No write is made to a byte address of BUF_BYTES or more. A byte of the window that lies inside the buffer is still patched.
- R9: `fixed_cnt_o` equals the number of reports applied. `done_o` is high for exactly one cycle. `fixed_cnt_o` and `fail_o` hold their values until the next accepted start.
- R10: Memory read data is taken one cycle after `mem_rd_o`. A read and a write never occur in the same cycle. A later report operates on the bytes as left by earlier reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| status_i | input | 32 | Decoder status: count 31:29, uncorrectable bit 1, error bit 0 |
| reports_i | input | 32*MAX_REPS (128) | Packed error-report words, report 0 in the low bits |
| mem_rd_o | output | 1 | Buffer read strobe |
| mem_we_o | output | 1 | Buffer write strobe |
| mem_addr_o | output | 10 | Buffer byte address |
| mem_wdata_o | output | 8 | Buffer write data |
| mem_rdata_i | input | 8 | Buffer read data, valid one cycle after the read strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Sector declared uncorrectable |
| fixed_cnt_o | output | 3 | Number of symbols patched |

## Verification
The bench builds the block with MAX_REPS = 4, BUF_BYTES = 512 and SYM_LIMIT = 512. The 3-bit count field can reach 7, so counts of 5 to 7 exercise the clamp to four reports. A 512-byte buffer is shorter than the 576 bytes that 512 packed symbols span, so indices at 455 and above reach the write-suppression path. At index 455 exactly, the first byte of the window is still patched and the second byte is suppressed. Random reports that repeat an index also test that a later report sees the bytes written by an earlier one.

// File: rtl/rs_patch_pkg.sv
package rs_patch_pkg;
  localparam int SYM_W      = 9;
  localparam int BYTE_AW    = 10;
  localparam int ST_CNT_LSB = 29;
  localparam int ST_CNT_W   = 3;
  localparam int ST_UNC_BIT = 1;
  localparam int ST_ERR_BIT = 0;
  localparam int REP_IDX_LSB = 16;
  localparam int REP_W      = 32;

  typedef struct packed {
    logic               valid;
    logic [BYTE_AW-1:0] byte_a;
    logic [2:0]         off;
    logic [SYM_W-1:0]   mask;
  } rep_dec_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_SEL, S_RD0, S_RD1, S_CAP, S_WR0, S_WR1, S_FIN
  } pstate_t;
endpackage

// File: rtl/rs_report_decode.sv
module rs_report_decode
  import rs_patch_pkg::*;
#(
  parameter int SYM_LIMIT = 512
) (
  input  logic [REP_W-1:0] word_i,
  output rep_dec_t         dec_o
);
  logic [SYM_W-1:0] field;
  logic [SYM_W-1:0] idx;
  logic             unused_bits;

  assign field = word_i[REP_IDX_LSB +: SYM_W];
  assign idx   = field - SYM_W'(1);
  assign unused_bits = ^{word_i[REP_W-1:REP_IDX_LSB+SYM_W], word_i[REP_IDX_LSB-1:SYM_W]};

  always_comb begin
    dec_o.valid  = (field != '0) && (int'(idx) < SYM_LIMIT);
    dec_o.byte_a = BYTE_AW'(idx) + BYTE_AW'(idx[SYM_W-1:3]);
    dec_o.off    = idx[2:0];
    dec_o.mask   = word_i[SYM_W-1:0];
  end

  // R7: a valid window's second byte stays inside the packed symbol span
  always_comb begin
    assert_span_R7: assert (!dec_o.valid || int'(dec_o.byte_a) + 1 < (SYM_LIMIT * SYM_W + 7) / 8 + 1);
  end
endmodule

// File: rtl/rs_window_xor.sv
module rs_window_xor
  import rs_patch_pkg::*;
(
  input  logic [7:0]       lo_i,
  input  logic [7:0]       hi_i,
  input  logic [2:0]       off_i,
  input  logic [SYM_W-1:0] mask_i,
  output logic [7:0]       lo_o,
  output logic [7:0]       hi_o
);
  logic [15:0] win;
  logic [15:0] flip;

  assign flip = {7'b0, mask_i} << off_i;
  assign win  = {hi_i, lo_i} ^ flip;
  assign lo_o = win[7:0];
  assign hi_o = win[15:8];

  // R7: exactly the mask's bits change in the window
  always_comb begin
    assert_xor_bits_R7: assert ($countones({hi_o, lo_o} ^ {hi_i, lo_i}) == $countones(mask_i));
  end
endmodule

// File: rtl/rs_patch_ctrl.sv
module rs_patch_ctrl
  import rs_patch_pkg::*;
#(
  parameter int MAX_REPS  = 4,
  parameter int BUF_BYTES = 512,
  localparam int KW = $clog2(MAX_REPS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               st_err_i,
  input  logic               st_unc_i,
  input  logic [ST_CNT_W-1:0] st_cnt_i,
  input  rep_dec_t           dec_i [MAX_REPS],
  input  logic [7:0]         mem_rdata_i,
  output logic               cap_o,
  output logic               mem_rd_o,
  output logic               mem_we_o,
  output logic [BYTE_AW-1:0] mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               fail_o,
  output logic [KW-1:0]      fixed_cnt_o
);
  pstate_t            st_q, st_d;
  logic [KW-1:0]      k_q, n_q, cnt_q, n_lim;
  logic               fail_q;
  logic [7:0]         lo_q, hi_q, new_lo, new_hi;
  rep_dec_t           cur;
  logic [BYTE_AW-1:0] a_hi;
  logic               in_lo, in_hi;

  always_comb begin
    cur = '0;
    for (int i = 0; i < MAX_REPS; i++)
      if (k_q == KW'(i)) cur = dec_i[i];
  end

  always_comb begin
    if (int'(st_cnt_i) > MAX_REPS) n_lim = KW'(MAX_REPS);
    else                           n_lim = KW'(st_cnt_i);
  end

  assign a_hi  = cur.byte_a + BYTE_AW'(1);
  assign in_lo = int'(cur.byte_a) < BUF_BYTES;
  assign in_hi = int'(a_hi) < BUF_BYTES;
  assign cap_o = (st_q == S_IDLE) && start_i;

  rs_window_xor u_win (
    .lo_i   (lo_q),
    .hi_i   (hi_q),
    .off_i  (cur.off),
    .mask_i (cur.mask),
    .lo_o   (new_lo),
    .hi_o   (new_hi)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (start_i) st_d = S_CHECK;
      S_CHECK: st_d = (st_unc_i || !st_err_i || n_lim == '0) ? S_FIN : S_SEL;
      S_SEL: begin
        if (k_q >= n_q)     st_d = S_FIN;
        else if (cur.valid) st_d = S_RD0;
      end
      S_RD0:   st_d = S_RD1;
      S_RD1:   st_d = S_CAP;
      S_CAP:   st_d = S_WR0;
      S_WR0:   st_d = S_WR1;
      S_WR1:   st_d = S_SEL;
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      k_q    <= '0;
      n_q    <= '0;
      cnt_q  <= '0;
      fail_q <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          k_q    <= '0;
          cnt_q  <= '0;
          fail_q <= 1'b0;
        end
        S_CHECK: begin
          n_q    <= n_lim;
          fail_q <= st_unc_i;
        end
        S_SEL: if (k_q < n_q && !cur.valid) k_q <= k_q + KW'(1);
        S_RD1: lo_q <= in_lo ? mem_rdata_i : 8'h00;
        S_CAP: hi_q <= in_hi ? mem_rdata_i : 8'h00;
        S_WR1: begin
          cnt_q <= cnt_q + KW'(1);
          k_q   <= k_q + KW'(1);
        end
        default: ;
      endcase
    end
  end

  assign mem_rd_o    = (st_q == S_RD0 && in_lo) || (st_q == S_RD1 && in_hi);
  assign mem_we_o    = (st_q == S_WR0 && in_lo) || (st_q == S_WR1 && in_hi);
  assign mem_addr_o  = (st_q == S_RD1 || st_q == S_WR1) ? a_hi : cur.byte_a;
  assign mem_wdata_o = (st_q == S_WR1) ? new_hi : new_lo;
  assign busy_o      = st_q != S_IDLE;
  assign done_o      = st_q == S_FIN;
  assign fail_o      = fail_q;
  assign fixed_cnt_o = cnt_q;

  assert_rdwe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_we_o));
  assert_wr_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> int'(mem_addr_o) < BUF_BYTES);
  assert_unc_nowrite_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && st_unc_i) |-> !mem_we_o);
  assert_noerr_nowrite_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !st_err_i) |-> !mem_we_o);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(fixed_cnt_o) && $stable(fail_o)));
  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fixed_cnt_o) <= MAX_REPS);
  assert_busy_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
endmodule

// File: rtl/rs_sym_patcher.sv
module rs_sym_patcher
  import rs_patch_pkg::*;
#(
  parameter int MAX_REPS  = 4,
  parameter int BUF_BYTES = 512,
  parameter int SYM_LIMIT = 512,
  localparam int KW = $clog2(MAX_REPS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [31:0]               status_i,
  input  logic [MAX_REPS*REP_W-1:0] reports_i,
  output logic                      mem_rd_o,
  output logic                      mem_we_o,
  output logic [BYTE_AW-1:0]        mem_addr_o,
  output logic [7:0]                mem_wdata_o,
  input  logic [7:0]                mem_rdata_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      fail_o,
  output logic [KW-1:0]             fixed_cnt_o
);
  logic                cap;
  logic                err_q, unc_q;
  logic [ST_CNT_W-1:0] cnt_field_q;
  logic [REP_W-1:0]    rep_q [MAX_REPS];
  rep_dec_t            dec   [MAX_REPS];
  logic                unused_status;

  assign unused_status = ^status_i[ST_CNT_LSB-1:ST_UNC_BIT+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q       <= 1'b0;
      unc_q       <= 1'b0;
      cnt_field_q <= '0;
      for (int i = 0; i < MAX_REPS; i++) rep_q[i] <= '0;
    end else if (cap) begin
      err_q       <= status_i[ST_ERR_BIT];
      unc_q       <= status_i[ST_UNC_BIT];
      cnt_field_q <= status_i[ST_CNT_LSB +: ST_CNT_W];
      for (int i = 0; i < MAX_REPS; i++) rep_q[i] <= reports_i[i*REP_W +: REP_W];
    end
  end

  for (genvar g = 0; g < MAX_REPS; g++) begin : g_dec
    rs_report_decode #(.SYM_LIMIT(SYM_LIMIT)) u_dec (
      .word_i (rep_q[g]),
      .dec_o  (dec[g])
    );
  end

  rs_patch_ctrl #(.MAX_REPS(MAX_REPS), .BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .st_err_i    (err_q),
    .st_unc_i    (unc_q),
    .st_cnt_i    (cnt_field_q),
    .dec_i       (dec),
    .mem_rdata_i (mem_rdata_i),
    .cap_o       (cap),
    .mem_rd_o    (mem_rd_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .fixed_cnt_o (fixed_cnt_o)
  );
endmodule

// File: tb/sim_rs_sym_patcher.sv
`timescale 1ns/1ps
module sim_rs_sym_patcher;
  localparam int MAXR = 4;
  localparam int BUFB = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] status = '0;
  logic [MAXR*32-1:0] reps = '0;
  logic mem_rd, mem_we, busy, done, fail;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [2:0] fixed_cnt;

  logic [7:0] mem  [BUFB];
  logic [7:0] refm [BUFB];
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rs_sym_patcher #(.MAX_REPS(MAXR), .BUF_BYTES(BUFB), .SYM_LIMIT(512)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .status_i(status), .reports_i(reps),
    .mem_rd_o(mem_rd), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .fail_o(fail),
    .fixed_cnt_o(fixed_cnt)
  );

  always @(posedge clk) begin
    if (mem_we && int'(mem_addr) < BUFB) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= (int'(mem_addr) < BUFB) ? mem[mem_addr] : 8'h00;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ref_apply(input logic [31:0] st, input logic [MAXR*32-1:0] rw,
                           output bit f, output int c);
    int n;
    f = 0; c = 0;
    if (st[1]) begin f = 1; return; end
    if (!st[0]) return;
    n = int'(st[31:29]);
    if (n > MAXR) n = MAXR;
    for (int k = 0; k < n; k++) begin
      logic [31:0] w;
      int fld, idx, a, off;
      logic [15:0] win;
      w = rw[k*32 +: 32];
      fld = int'(w[24:16]);
      if (fld == 0) continue;
      idx = fld - 1;
      a = idx + (idx >> 3);
      off = idx & 7;
      win = {(a + 1 < BUFB) ? refm[a+1] : 8'h00, (a < BUFB) ? refm[a] : 8'h00};
      win = win ^ (16'(w[8:0]) << off);
      if (a < BUFB) refm[a] = win[7:0];
      if (a + 1 < BUFB) refm[a+1] = win[15:8];
      c++;
    end
  endtask

  task automatic run_case(input logic [31:0] st, input logic [MAXR*32-1:0] rw, input string tag);
    bit ef; int ec; int t; int diff;
    ref_apply(st, rw, ef, ec);
    @(negedge clk);
    status = st; reps = rw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    status = ~st; reps = ~rw;  // inputs after capture must not matter (R2)
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    if (t >= 200) begin
      chk(0, "R9 watchdog expired", t, 0);
      return;
    end
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    chk(fail == ef, {"R3 fail ", tag}, fail, ef);
    chk(int'(fixed_cnt) == ec, {"R9 count ", tag}, fixed_cnt, ec);
    diff = 0;
    for (int i = 0; i < BUFB; i++) if (mem[i] !== refm[i]) diff++;
    chk(diff == 0, {"R7 buffer bytes differing ", tag}, diff, 0);
  endtask

  function automatic logic [31:0] rep(input int fld, input int msk);
    return {7'b0, 9'(fld), 7'b0, 9'(msk)};
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < BUFB; i++) begin
      mem[i] = 8'($urandom);
      refm[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && fail == 0, "R1 flags at reset", {busy, done, fail}, 0);
    chk(fixed_cnt == 0 && mem_rd == 0 && mem_we == 0, "R1 count/strobes at reset",
        {fixed_cnt, mem_rd, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 uncorrectable: nothing written
    run_case(32'h8000_0003, {rep(9, 9'h1FF), rep(2, 9'h0F0), rep(1, 9'h0AA), rep(5, 9'h155)}, "R3");
    // R4 error flag clear
    run_case(32'h4000_0000, {64'h0, rep(3, 9'h1FF), rep(1, 9'h1FF)}, "R4");
    // R6 index field 0 skipped; R7 index 1 -> byte 0 offset 0
    run_case(32'h4000_0001, {64'h0, rep(0, 9'h1FF), rep(1, 9'h1FF)}, "R6");
    // R7 straddle: field 8 -> idx 7, byte 7, offset 7
    run_case(32'h2000_0001, {96'h0, rep(8, 9'h1A5)}, "R7 straddle");
    // R8 field 456 -> idx 455 -> byte 511, second byte suppressed
    run_case(32'h2000_0001, {96'h0, rep(456, 9'h1FF)}, "R8 edge");
    // R8 window entirely outside buffer
    run_case(32'h2000_0001, {96'h0, rep(511, 9'h1FF)}, "R8 beyond");
    // R5 count 7 clamped to 4
    run_case(32'hE000_0001, {rep(40, 9'h003), rep(30, 9'h100), rep(20, 9'h011), rep(10, 9'h0FF)}, "R5 clamp");
    // R5 count 1: later reports ignored
    run_case(32'h2000_0001, {rep(50, 9'h1FF), rep(60, 9'h1FF), rep(70, 9'h1FF), rep(33, 9'h07E)}, "R5 one");
    // R10 same symbol twice and an overlapping neighbour
    run_case(32'h6000_0001, {rep(14, 9'h0F0), rep(13, 9'h155), rep(12, 9'h1C3), rep(12, 9'h1C3)}, "R10 overlap");

    // R9 hold after done
    begin
      logic [2:0] c0; logic f0;
      c0 = fixed_cnt; f0 = fail;
      repeat (5) @(negedge clk);
      chk(fixed_cnt == c0 && fail == f0, "R9 hold while idle", {fixed_cnt, fail}, {c0, f0});
    end

    // R2 start while busy is ignored
    @(negedge clk);
    status = 32'h2000_0001; reps = {96'h0, rep(100, 9'h1FF)}; start = 1'b1;
    begin
      bit ef; int ec;
      ref_apply(status, reps, ef, ec);
    end
    @(negedge clk);
    status = 32'h8000_0003; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int t = 0; int diff = 0;
      while (!done && t < 200) begin @(negedge clk); t++; end
      @(negedge clk);
      chk(fail == 0 && fixed_cnt == 1, "R2 start while busy ignored", {fail, fixed_cnt}, 1);
      for (int i = 0; i < BUFB; i++) if (mem[i] !== refm[i]) diff++;
      chk(diff == 0, "R2 buffer after ignored start", diff, 0);
    end

    // random mix
    for (int trial = 0; trial < 80; trial++) begin
      logic [31:0] st;
      logic [MAXR*32-1:0] rw;
      int r;
      r = $urandom % 10;
      st = {3'($urandom), 27'($urandom), (r == 0), (r != 1)};
      for (int k = 0; k < MAXR; k++) begin
        int sel, fld;
        sel = $urandom % 8;
        if (sel == 0) fld = 0;
        else if (sel == 1) fld = 456 + ($urandom % 56);
        else if (sel == 2) fld = 1 + ($urandom % 16);
        else fld = 1 + ($urandom % 511);
        rw[k*32 +: 32] = {7'($urandom), 9'(fld), 7'($urandom), 9'($urandom)};
      end
      run_case(st, rw, "R6 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 global watchdog actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule